// File: doc/BRIEF.md
# Timed-Unlock Clock Command Register

This block is a single 8-bit control and status register for a small processor bus. It gates clock-source commands behind a short, self-closing write window. Software first writes an unlock pattern: only the top bit set, every other bit zero. That opens a window four bus cycles long. While the window is open, the next write of any other value is taken as a command. Its low four bits are stored and sent out as a one-cycle strobe with the code, and the window closes at once.

A read-only ready flag reports what an external clock-availability checker says about the selected clock. Two command codes mark a fresh availability question and clear that flag. The flag then stays low until the checker reports the clock stable again, which may take any time or never happen.

The register reads back with no side effects. The oscillators, the clock switch, the start-up timers and any divider that the commands steer all lie outside this block.

Top module: `clkcmd_gate`

## Requirements
- R1: Read layout: bit 7 is the window-open flag, bits 6:5 always read 0, bit 4 is the ready flag, and bits 3:0 hold the last accepted command code. After a synchronous reset the register reads 0x00 and `cmd_valid` is low.
- R2: The window opens only on a write of exactly 0x80 while it is closed. A write with bit 7 set and any of bits 6:0 nonzero leaves it closed.
- R3: After the unlock write, bit 7 reads 1 for exactly four cycles and then clears by itself. A command write in any of those four cycles is accepted. A command write in the fifth cycle is not.
- R4: While the window is open, a write of any value other than 0x80 is accepted as a command. One cycle later `cmd_valid` is high for exactly one cycle, `cmd_code` and bits 3:0 equal the written bits 3:0, and bit 7 reads 0.
- R5: A write of 0x80 while the window is open is ignored. It produces no strobe, does not close the window and does not extend it.
- R6: While the window is closed, writes other than 0x80 change nothing. Bits 3:0 keep their value and no strobe is produced.
- R7: The ready flag (bit 4) sets in the cycle after `clk_stable` is sampled high. It stays set when `clk_stable` falls. Writes to bit 4 have no effect on it.
- R8: An accepted command with code 0x1 (request availability) or 0x3 (enable source) clears the ready flag, and the clear takes priority over `clk_stable` in that cycle. Other codes, including undefined ones, are still strobed out and leave the flag unchanged.
- R9: Reset asserted while the window is open clears every register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| clk_stable | input | 1 | Availability checker: selected clock running and stable |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 4 | Code of the last accepted command |

## Verification
The bench targets the edges of the window.
- A command in the fourth open cycle must be taken, and one in the fifth must be dropped. An off-by-one counter either loses the last slot or grants an extra one.
- An unlock write with stray bits set must not open the window.
- A repeated unlock in mid-window must not restart the countdown. A design that restarts it stays open for six cycles, and one that treats the repeat as a command emits a spurious strobe.
- On the ready flag, a clearing command issued while the checker still reports stable must win for one cycle. The flag must then stay low when no clock ever arrives. An undefined code must pass through without touching the flag.

// File: rtl/clkcmd_pkg.sv
package clkcmd_pkg;
  localparam int REG_W   = 8;
  localparam int CMD_W   = 4;
  localparam int OPEN_B  = 7;
  localparam int RDY_B   = 4;
  localparam logic [REG_W-1:0] UNLOCK_PAT = 8'h80;

  function automatic logic is_unlock(input logic [REG_W-1:0] d);
    return d == UNLOCK_PAT;
  endfunction
endpackage

// File: rtl/clkcmd_window.sv
module clkcmd_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic unlock_req,
  input  logic cmd_take,
  output logic open
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      open <= 1'b0;
      cnt  <= '0;
    end else if (open) begin
      if (cmd_take || cnt == LAST) begin
        open <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (unlock_req) begin
      open <= 1'b1;
      cnt  <= '0;
    end
  end
endmodule

// File: rtl/clkcmd_ready.sv
module clkcmd_ready (
  input  logic clk,
  input  logic rst,
  input  logic stable_in,
  input  logic clr,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (rst)            ready <= 1'b0;
    else if (clr)       ready <= 1'b0;
    else if (stable_in) ready <= 1'b1;
  end
endmodule

// File: rtl/clkcmd_issue.sv
module clkcmd_issue #(
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CMD_W-1:0] code_in,
  output logic             valid,
  output logic [CMD_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= '0;
    end else begin
      valid <= take;
      if (take) code <= code_in;
    end
  end
endmodule

// File: rtl/clkcmd_gate.sv
module clkcmd_gate
  import clkcmd_pkg::*;
#(
  parameter int         WINDOW     = 4,
  parameter logic [3:0] CLR_CODE_A = 4'h1,
  parameter logic [3:0] CLR_CODE_B = 4'h3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             clk_stable,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code
);
  logic open, ready;
  logic unlock_pat, unlock_req, cmd_take, rdy_clr;
  logic [CMD_W-1:0] new_code;

  assign unlock_pat = is_unlock(wr_data);
  assign new_code   = wr_data[CMD_W-1:0];
  assign unlock_req = wr_en && unlock_pat && !open;
  assign cmd_take   = wr_en && open && !unlock_pat;
  assign rdy_clr    = cmd_take && (new_code == CLR_CODE_A || new_code == CLR_CODE_B);

  clkcmd_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk), .rst(rst), .unlock_req(unlock_req), .cmd_take(cmd_take), .open(open)
  );

  clkcmd_ready u_ready (
    .clk(clk), .rst(rst), .stable_in(clk_stable), .clr(rdy_clr), .ready(ready)
  );

  clkcmd_issue #(.CMD_W(CMD_W)) u_issue (
    .clk(clk), .rst(rst), .take(cmd_take), .code_in(new_code),
    .valid(cmd_valid), .code(cmd_code)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[OPEN_B]        = open;
    rd_data[RDY_B]         = ready;
    rd_data[CMD_W-1:0]     = cmd_code;
  end
endmodule

// File: rtl/clkcmd_gate_chk.sv
module clkcmd_gate_chk #(
  parameter int WINDOW = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       clk_stable,
  input logic       cmd_valid,
  input logic [3:0] cmd_code
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (rst)             run <= '0;
    else if (!rd_data[7]) run <= '0;
    else if (run != 8'hFF) run <= run + 1'b1;
  end

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[6:5] == 2'b00);

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] |-> (run < 8'(WINDOW)));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R4
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_data[7] && wr_data != 8'h80) |=> (cmd_valid && !rd_data[7] && cmd_code == $past(wr_data[3:0])));

  // R6
  locked_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[7]) |=> (!cmd_valid && $stable(cmd_code)));

  // R5
  relock_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == 8'h80 && rd_data[7]) |=> !cmd_valid);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[4]) |-> $past(clk_stable));

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 4'h1 || cmd_code == 4'h3)) |-> !rd_data[4]);
endmodule

bind clkcmd_gate clkcmd_gate_chk #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .clk_stable(clk_stable), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/clkcmd_gate_bench.sv
`timescale 1ns/1ps
module clkcmd_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clk_stable = 1'b0;
  logic [7:0] rd_data;
  logic       cmd_valid;
  logic [3:0] cmd_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkcmd_gate u_clkcmd_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .clk_stable(clk_stable), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_locked();
    wr(8'h05);
    chk("R6 locked strobe", cmd_valid, 0);
    chk("R6 locked rd_data", rd_data, 8'h00);
    wr(8'h81);
    chk("R2 bad unlock open bit", rd_data[7], 0);
    wr(8'h06);
    chk("R2 bad unlock then cmd", cmd_valid, 0);
  endtask

  task automatic t_window_len();
    int n = 0;
    wr(8'h80);
    while (rd_data[7] && n < 10) begin n++; tick(1); end
    chk("R3 open cycles", n, 4);
    wr(8'h07);
    chk("R6 after timeout", cmd_valid, 0);
  endtask

  task automatic t_accept();
    wr(8'h80);
    wr(8'h06);
    chk("R4 strobe", cmd_valid, 1);
    chk("R4 code", cmd_code, 6);
    chk("R4 rd_data", rd_data, 8'h06);
    tick(1);
    chk("R4 strobe one cycle", cmd_valid, 0);
    wr(8'h80); tick(3);
    wr(8'h0A);
    chk("R3 last slot strobe", cmd_valid, 1);
    chk("R3 last slot code", cmd_code, 4'hA);
    wr(8'h80); tick(4);
    wr(8'h0C);
    chk("R3 fifth cycle dropped", cmd_valid, 0);
    chk("R6 code kept", rd_data[3:0], 4'hA);
  endtask

  task automatic t_relock();
    int n = 0;
    wr(8'h80); tick(1);
    wr(8'h80);
    chk("R5 no strobe", cmd_valid, 0);
    while (rd_data[7] && n < 10) begin n++; tick(1); end
    chk("R5 not extended", n, 2);
  endtask

  task automatic t_ready();
    wr(8'h10);
    chk("R7 write bit4 ignored", rd_data[4], 0);
    clk_stable = 1'b1; tick(1);
    chk("R7 ready set", rd_data[4], 1);
    clk_stable = 1'b0; tick(1);
    chk("R7 ready sticky", rd_data[4], 1);
    wr(8'h80); wr(8'h0F);
    chk("R8 undefined code strobe", cmd_code, 4'hF);
    chk("R8 undefined code keeps ready", rd_data[4], 1);
    wr(8'h80); wr(8'h01);
    chk("R8 code 1 clears ready", rd_data[4], 0);
    tick(10);
    chk("R8 no clock stays low", rd_data[4], 0);
    clk_stable = 1'b1; tick(1);
    chk("R7 ready set again", rd_data[4], 1);
    wr(8'h80); wr(8'h83);
    chk("R8 code 3 clear wins", rd_data[4], 0);
    chk("R4 code with bit7 set", cmd_code, 3);
    tick(1);
    chk("R7 ready resets after clear", rd_data[4], 1);
    clk_stable = 1'b0;
  endtask

  task automatic t_reset_mid();
    wr(8'h80);
    rst = 1'b1; tick(1); rst = 1'b0;
    chk("R9 reset mid-window", rd_data, 8'h00);
    chk("R9 reset strobe", cmd_valid, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_window_len();
    t_accept();
    t_relock();
    t_ready();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule